// File: doc/BRIEF.md
# Per-Resource Compartment Access Filter

This block sits in front of a memory controller and decides, request by request, whether a bus requester may use one of six isolatable resources. Resource 0 is the shared configuration register, resources 1 to 4 are the chip-select controllers for banks 1 to 4, and resource 5 is the NAND flash controller. Each request carries a resource index, a 3-bit compartment ID (CID) and a secure attribute. The block answers one clock later with grant or deny.

The rules for each resource are checked in a fixed order. The first check is the controller's isolation status. The second is the resource's secure bit. The third is CID filtering, which has two modes. In the static mode the resource has a single owner CID. In the semaphore mode, a CID on an allow-list first takes a hardware semaphore and then owns the resource until it releases it. Configuration is held in word-addressed registers on a simple read/write port. The same port carries the semaphore take and release writes.

Top module: `cid_access_filter`

## Requirements
- R1: `resp_valid` is high exactly one clock after `req_valid`. In a response cycle exactly one of `resp_grant` and `resp_deny` is high, and both are low otherwise.
- R2: A request whose resource index is 6 or above is denied, whatever its CID or secure attribute.
- R3: The secure register at offset 0x300 holds one bit per resource, bit n for resource n. A set bit denies non-secure requests to that resource. Secure requests go on to the CID checks.
- R4: While bit 0 of a resource's CID configuration register (offset 0x30C + 8·n) is clear, CID filtering is off and the request is granted.
- R5: With filtering on and bit 1 of the CID configuration register clear, a request is granted only when its CID equals bits 6:4 of that register.
- R6: With bits 0 and 1 of the CID configuration register set (semaphore mode), allow-list bit 16+c governs CID c. A CID whose allow bit is clear is denied, and its writes of 1 to the semaphore do not take it.
- R7: The semaphore register of resource n sits at offset 0x310 + 8·n. When an allowed CID writes 1 to bit 0 while the semaphore is free, bit 0 reads back 1 and bits 6:4 hold the writer's CID. In semaphore mode a request is granted only while the semaphore is held and its recorded CID equals the request's CID.
- R8: A write of 1 to bit 0 of a semaphore that is already held leaves the holder unchanged.
- R9: A write of 0 to bit 0 releases a semaphore only when it comes from the recorded CID. A release clears bit 0 and bits 6:4. A write of 0 from any other CID has no effect.
- R10: Writes to the secure register and to the CID configuration registers take effect only when `reg_secure` is high. Non-secure writes to them leave their read-back values unchanged.
- R11: The status register at offset 0x84 reports in bits 1:0 the `iso_status` value sampled on the previous clock. While that value is non-zero, every request is denied.
- R12: Read data appears on `reg_rdata` one clock after a read and is held until the next read. A read of an unmapped offset returns 0. Stored fields that are unused read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register port access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_cid | input | 3 | CID of the register port requester |
| reg_secure | input | 1 | Secure attribute of the register port access |
| reg_rdata | output | 32 | Registered read data |
| iso_status | input | 2 | Isolation status of the controller, 0 = ready |
| req_valid | input | 1 | Access request strobe |
| req_res | input | 3 | Resource index of the request |
| req_cid | input | 3 | Requester CID |
| req_secure | input | 1 | Secure attribute of the request |
| resp_valid | output | 1 | Decision is present |
| resp_grant | output | 1 | Access granted |
| resp_deny | output | 1 | Access denied |

## Verification
The decision and the read data both come from a single register stage. They are due at the first clock edge after the request or read. A register or semaphore write issued in the same cycle as a request affects only the requests of later cycles. The bench drives one cycle's stimulus on the falling edge. It works out that cycle's expected response from its model state before applying the cycle's write. It compares all outputs on the next falling edge, so each result is checked in the cycle it is due. Status samples `iso_status` through one register, so the model updates its status copy after evaluating the same cycle's request.

// File: rtl/cidf_pkg.sv
package cidf_pkg;

  localparam int CID_W = 3;
  localparam int NCID  = 1 << CID_W;

  // Stored fields of one CID configuration register
  typedef struct packed {
    logic [NCID-1:0]  allow;
    logic [CID_W-1:0] scid;
    logic             semen;
    logic             cfen;
  } cidcfg_t;

  // Semaphore state of one resource
  typedef struct packed {
    logic             held;
    logic [CID_W-1:0] owner;
  } sema_t;

  function automatic logic [31:0] cfg_to_word(input cidcfg_t c);
    logic [31:0] w;
    w           = '0;
    w[0]        = c.cfen;
    w[1]        = c.semen;
    w[6:4]      = c.scid;
    w[16+:NCID] = c.allow;
    return w;
  endfunction

  function automatic cidcfg_t word_to_cfg(input logic [31:0] w);
    cidcfg_t c;
    c.cfen  = w[0];
    c.semen = w[1];
    c.scid  = w[6:4];
    c.allow = w[16+:NCID];
    return c;
  endfunction

  function automatic logic [31:0] sema_to_word(input sema_t s);
    logic [31:0] w;
    w      = '0;
    w[0]   = s.held;
    w[6:4] = s.owner;
    return w;
  endfunction

  // Priority-ordered rule chain for an in-range resource
  function automatic logic rule_chain(input logic             stat_busy,
                                      input logic             res_secure,
                                      input logic             rq_secure,
                                      input cidcfg_t          c,
                                      input sema_t            s,
                                      input logic [CID_W-1:0] cid);
    if (stat_busy)                 return 1'b0;
    if (res_secure && !rq_secure)  return 1'b0;
    if (!c.cfen)                   return 1'b1;
    if (!c.semen)                  return (cid == c.scid);
    if (!c.allow[cid])             return 1'b0;
    return s.held && (s.owner == cid);
  endfunction

endpackage

// File: rtl/cidf_regfile.sv
module cidf_regfile
  import cidf_pkg::*;
#(
  parameter int NUM_RES = 6,
  parameter int ADDR_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_en,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  input  logic                       reg_secure,
  input  logic [1:0]                 iso_status,
  input  sema_t   [NUM_RES-1:0]      sema_st,
  output logic    [NUM_RES-1:0]      sec_q,
  output cidcfg_t [NUM_RES-1:0]      cfg_q,
  output logic    [1:0]              status_q,
  output logic    [NUM_RES-1:0]      sem_wr,
  output logic [31:0]                reg_rdata
);

  localparam int SEC_OFF  = 'h300;
  localparam int STAT_OFF = 'h084;
  localparam int CID_OFF  = 'h30C;
  localparam int SEM_OFF  = 'h310;
  localparam int STRIDE   = 8;

  logic               hit_sec, hit_stat;
  logic [NUM_RES-1:0] hit_cid, hit_sem;
  logic               wr_any, wr_cfg_ok;
  logic [31:0]        rd_mux;

  always_comb begin
    hit_sec  = (reg_addr == ADDR_W'(SEC_OFF));
    hit_stat = (reg_addr == ADDR_W'(STAT_OFF));
    for (int i = 0; i < NUM_RES; i++) begin
      hit_cid[i] = (reg_addr == ADDR_W'(CID_OFF + STRIDE * i));
      hit_sem[i] = (reg_addr == ADDR_W'(SEM_OFF + STRIDE * i));
    end
  end

  assign wr_any    = reg_en && reg_we;
  assign wr_cfg_ok = wr_any && reg_secure;
  assign sem_wr    = {NUM_RES{wr_any}} & hit_sem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q    <= '0;
      cfg_q    <= '0;
      status_q <= '0;
    end else begin
      status_q <= iso_status;
      if (wr_cfg_ok && hit_sec) sec_q <= reg_wdata[NUM_RES-1:0];
      for (int i = 0; i < NUM_RES; i++)
        if (wr_cfg_ok && hit_cid[i]) cfg_q[i] <= word_to_cfg(reg_wdata);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_sec)  rd_mux[NUM_RES-1:0] = sec_q;
    if (hit_stat) rd_mux[1:0]         = status_q;
    for (int i = 0; i < NUM_RES; i++) begin
      if (hit_cid[i]) rd_mux = cfg_to_word(cfg_q[i]);
      if (hit_sem[i]) rd_mux = sema_to_word(sema_st[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                reg_rdata <= '0;
    else if (reg_en && !reg_we) reg_rdata <= rd_mux;
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[31:24], reg_wdata[15:7], reg_wdata[3:2]};

  // R10: non-secure writes leave configuration untouched
  a_r10_nonsec_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !reg_secure) |=> ($stable(sec_q) && $stable(cfg_q)));

  // R12: no read keeps read data stable
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_en && !reg_we) |=> $stable(reg_rdata));

endmodule

// File: rtl/cidf_sema.sv
module cidf_sema
  import cidf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             wbit,
  input  logic [CID_W-1:0] wcid,
  input  logic             sem_mode,
  input  logic [NCID-1:0]  allow,
  output sema_t            st
);

  logic take_ok, rel_ok;

  assign take_ok = wr && wbit && !st.held && sem_mode && allow[wcid];
  assign rel_ok  = wr && !wbit && st.held && (st.owner == wcid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else if (take_ok) begin
      st.held  <= 1'b1;
      st.owner <= wcid;
    end else if (rel_ok) begin
      st.held  <= 1'b0;
      st.owner <= '0;
    end
  end

  // R8: a held semaphore is not retaken
  a_r8_no_steal: assert property (@(posedge clk) disable iff (!rst_n)
    (st.held && wr && wbit) |=> (st.held && $stable(st.owner)));

  // R9: only the recorded CID releases
  a_r9_foreign_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st.held && wr && !wbit && (wcid != st.owner)) |=> (st.held && $stable(st.owner)));

  a_r9_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ok |=> (!st.held && (st.owner == '0)));

  // R6: a CID off the allow-list never takes
  a_r6_blocked_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!st.held && wr && wbit && !allow[wcid]) |=> !st.held);

  // R7: a successful take records the writer
  a_r7_take_records: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> (st.held && (st.owner == $past(wcid))));

endmodule

// File: rtl/cidf_decide.sv
module cidf_decide
  import cidf_pkg::*;
#(
  parameter int NUM_RES = 6,
  parameter int RES_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [RES_W-1:0]      req_res,
  input  logic [CID_W-1:0]      req_cid,
  input  logic                  req_secure,
  input  logic [NUM_RES-1:0]    sec_q,
  input  cidcfg_t [NUM_RES-1:0] cfg_q,
  input  sema_t   [NUM_RES-1:0] sema_st,
  input  logic [1:0]            status_q,
  output logic                  resp_valid,
  output logic                  resp_grant,
  output logic                  resp_deny
);

  logic             in_range;
  logic [RES_W-1:0] idx;
  logic             ok_now;

  assign in_range = (int'(req_res) < NUM_RES);
  assign idx      = in_range ? req_res : '0;
  assign ok_now   = in_range &&
                    rule_chain(status_q != 2'b00, sec_q[idx], req_secure,
                               cfg_q[idx], sema_st[idx], req_cid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_grant <= req_valid && ok_now;
    end
  end

  assign resp_deny = resp_valid && !resp_grant;

  // R1: one-cycle response, grant only within a response
  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  a_r1_grant_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_grant |-> resp_valid);

  // R2: out-of-range index denied
  a_r2_range_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (int'(req_res) >= NUM_RES)) |=> resp_deny);

  // R3: secure resource refuses non-secure requests
  a_r3_secure_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_range && sec_q[idx] && !req_secure) |=> resp_deny);

  // R11: not-ready status denies all
  a_r11_busy_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (status_q != 2'b00)) |=> resp_deny);

endmodule

// File: rtl/cid_access_filter.sv
module cid_access_filter
  import cidf_pkg::*;
#(
  parameter int NUM_RES = 6,
  parameter int ADDR_W  = 12,
  parameter int RES_W   = $clog2(NUM_RES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [2:0]        reg_cid,
  input  logic              reg_secure,
  output logic [31:0]       reg_rdata,
  input  logic [1:0]        iso_status,
  input  logic              req_valid,
  input  logic [RES_W-1:0]  req_res,
  input  logic [2:0]        req_cid,
  input  logic              req_secure,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic              resp_deny
);

  logic    [NUM_RES-1:0] sec_q;
  cidcfg_t [NUM_RES-1:0] cfg_q;
  sema_t   [NUM_RES-1:0] sema_st;
  logic    [NUM_RES-1:0] sem_wr;
  logic    [1:0]         status_q;

  cidf_regfile #(.NUM_RES(NUM_RES), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_secure (reg_secure),
    .iso_status (iso_status),
    .sema_st    (sema_st),
    .sec_q      (sec_q),
    .cfg_q      (cfg_q),
    .status_q   (status_q),
    .sem_wr     (sem_wr),
    .reg_rdata  (reg_rdata)
  );

  for (genvar g = 0; g < NUM_RES; g++) begin : g_sema
    cidf_sema u_sema (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (sem_wr[g]),
      .wbit     (reg_wdata[0]),
      .wcid     (reg_cid),
      .sem_mode (cfg_q[g].cfen && cfg_q[g].semen),
      .allow    (cfg_q[g].allow),
      .st       (sema_st[g])
    );
  end

  cidf_decide #(.NUM_RES(NUM_RES), .RES_W(RES_W)) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_res    (req_res),
    .req_cid    (req_cid),
    .req_secure (req_secure),
    .sec_q      (sec_q),
    .cfg_q      (cfg_q),
    .sema_st    (sema_st),
    .status_q   (status_q),
    .resp_valid (resp_valid),
    .resp_grant (resp_grant),
    .resp_deny  (resp_deny)
  );

endmodule

// File: tb/cid_access_filter_tb.sv
module cid_access_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0, reg_secure = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_cid = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  iso_status = '0;
  logic        req_valid = 1'b0, req_secure = 1'b0;
  logic [2:0]  req_res = '0, req_cid = '0;
  logic        resp_valid, resp_grant, resp_deny;

  always #5 clk = ~clk;

  cid_access_filter u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_cid(reg_cid), .reg_secure(reg_secure), .reg_rdata(reg_rdata),
    .iso_status(iso_status),
    .req_valid(req_valid), .req_res(req_res), .req_cid(req_cid), .req_secure(req_secure),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_deny(resp_deny)
  );

  // Behavioural model state
  int unsigned m_sec;
  int unsigned m_cfg[6];
  bit          m_held[6];
  int unsigned m_own[6];
  int unsigned m_stat;
  int unsigned m_rd;
  int          n_vec = 0, n_bad = 0;

  function automatic int res_of(input int unsigned a, input int unsigned base);
    for (int k = 0; k < 6; k++) if (a == base + 8 * k) return k;
    return -1;
  endfunction

  function automatic bit m_grant(input int r, input int c, input bit s);
    int unsigned w;
    if (r >= 6) return 0;
    if (m_stat != 0) return 0;
    if (m_sec[r] && !s) return 0;
    w = m_cfg[r];
    if (!w[0]) return 1;
    if (!w[1]) return c == ((w >> 4) & 7);
    if (!w[16 + c]) return 0;
    return m_held[r] && (m_own[r] == c);
  endfunction

  function automatic int unsigned m_read(input int unsigned a);
    int k;
    if (a == 'h300) return m_sec;
    if (a == 'h084) return m_stat;
    k = res_of(a, 'h30C);
    if (k >= 0) return m_cfg[k];
    k = res_of(a, 'h310);
    if (k >= 0) return (m_held[k] ? 1 : 0) | (m_own[k] << 4);
    return 0;
  endfunction

  task automatic m_write(input int unsigned a, input int unsigned d, input int c, input bit s);
    int k;
    int unsigned w;
    if (s && a == 'h300) m_sec = d & 'h3F;
    k = res_of(a, 'h30C);
    if (s && k >= 0) m_cfg[k] = d & 'h00FF0073;
    k = res_of(a, 'h310);
    if (k >= 0) begin
      w = m_cfg[k];
      if (d[0] && !m_held[k] && w[0] && w[1] && w[16 + c]) begin
        m_held[k] = 1; m_own[k] = c;
      end else if (!d[0] && m_held[k] && m_own[k] == c) begin
        m_held[k] = 0; m_own[k] = 0;
      end
    end
  endtask

  // One clock of stimulus: called on a falling edge, compares on the next one
  task automatic step(input string tag,
                      input bit en, input bit we, input int unsigned a, input int unsigned d,
                      input int wc, input bit ws,
                      input bit rv, input int rr, input int rc, input bit rs);
    bit exp_v, exp_g;
    reg_en = en; reg_we = we; reg_addr = a[11:0]; reg_wdata = d;
    reg_cid = wc[2:0]; reg_secure = ws;
    req_valid = rv; req_res = rr[2:0]; req_cid = rc[2:0]; req_secure = rs;
    exp_v = rv;
    exp_g = rv && m_grant(rr, rc, rs);
    if (en && !we) m_rd = m_read(a);
    if (en && we) m_write(a, d, wc, ws);
    m_stat = iso_status;
    @(negedge clk);
    n_vec++;
    if (resp_valid !== exp_v || resp_grant !== exp_g || resp_deny !== (exp_v && !exp_g)
        || reg_rdata !== m_rd) begin
      n_bad++;
      $display("FAIL %s: got v=%0b g=%0b d=%0b rd=%h, expected v=%0b g=%0b d=%0b rd=%h",
               tag, resp_valid, resp_grant, resp_deny, reg_rdata,
               exp_v, exp_g, exp_v && !exp_g, m_rd);
    end
  endtask

  task automatic wr(input string t, input int unsigned a, input int unsigned d, input int c, input bit s);
    step(t, 1, 1, a, d, c, s, 0, 0, 0, 0);
  endtask
  task automatic rd(input string t, input int unsigned a);
    step(t, 1, 0, a, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic rq(input string t, input int r, input int c, input bit s);
    step(t, 0, 0, 0, 0, 0, 0, 1, r, c, s);
  endtask
  task automatic idle(input string t);
    step(t, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  bit done = 0;

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_sec = 0; m_stat = 0; m_rd = 0;
    for (int k = 0; k < 6; k++) begin m_cfg[k] = 0; m_held[k] = 0; m_own[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    rd("R12 unmapped read", 'h100);
    rq("R4 filter off grants", 0, 2, 0);
    rq("R1 back-to-back", 5, 7, 0);
    // R10: non-secure configuration writes ignored
    wr("R10 nonsec sec write", 'h300, 'h3F, 1, 0);
    rd("R10 sec readback", 'h300);
    wr("R10 nonsec cfg write", 'h30C + 8 * 1, 'h51, 1, 0);
    rd("R10 cfg readback", 'h30C + 8 * 1);
    rq("R10 still open", 1, 4, 0);
    // R3: secure bit for resource 2
    wr("R3 set secure", 'h300, 'h04, 0, 1);
    rd("R3 readback", 'h300);
    rq("R3 nonsec denied", 2, 1, 0);
    rq("R3 secure passes", 2, 1, 1);
    rq("R3 neighbour open", 3, 1, 0);
    // R2: index range
    rq("R2 index 6", 6, 1, 1);
    rq("R2 index 7", 7, 0, 0);
    // R5: static owner 5 on resource 1
    wr("R5 static cfg", 'h30C + 8 * 1, 'hFFFF_FF51, 0, 1);
    rd("R12 cfg masked readback", 'h30C + 8 * 1);
    rq("R5 owner grant", 1, 5, 0);
    rq("R5 other deny", 1, 4, 0);
    rq("R5 secure other deny", 1, 0, 1);
    // R6..R9: semaphore on resource 4, CIDs 1 and 3 allowed
    wr("R6 sem cfg", 'h30C + 8 * 4, 'h000A_0003, 0, 1);
    rq("R7 free sem deny", 4, 1, 0);
    wr("R6 blocked take", 'h310 + 8 * 4, 1, 2, 0);
    rd("R6 sem readback", 'h310 + 8 * 4);
    rq("R6 blocked cid deny", 4, 2, 0);
    step("R7 take same cycle as req", 1, 1, 'h310 + 8 * 4, 1, 1, 0, 1, 4, 1, 0);
    rd("R7 sem readback", 'h310 + 8 * 4);
    rq("R7 owner grant", 4, 1, 0);
    rq("R7 other allowed deny", 4, 3, 0);
    wr("R8 steal attempt", 'h310 + 8 * 4, 1, 3, 0);
    rd("R8 holder kept", 'h310 + 8 * 4);
    wr("R9 foreign release", 'h310 + 8 * 4, 0, 3, 1);
    rd("R9 still held", 'h310 + 8 * 4);
    wr("R9 owner release", 'h310 + 8 * 4, 0, 1, 0);
    rd("R9 cleared", 'h310 + 8 * 4);
    rq("R9 released deny", 4, 1, 0);
    wr("R7 retake", 'h310 + 8 * 4, 1, 3, 0);
    rd("R7 new owner", 'h310 + 8 * 4);
    rq("R7 new owner grant", 4, 3, 0);
    wr("R6 take in static mode", 'h310 + 8 * 1, 1, 5, 0);
    rd("R6 static sem stays free", 'h310 + 8 * 1);
    // R11: isolation status
    iso_status = 2'b10;
    idle("R11 sample");
    rd("R11 status read", 'h084);
    rq("R11 busy deny", 0, 0, 1);
    rq("R11 busy deny owner", 4, 3, 0);
    iso_status = 2'b00;
    idle("R11 clear");
    rq("R11 ready grant", 4, 3, 0);
    // Sweep every index with both attributes
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c += 3) begin
        rq("R2 sweep", r, c, 0);
        rq("R3 sweep", r, c, 1);
      end
    idle("R1 drain");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule